// File: doc/BRIEF.md
# Per-Bit Split Interrupt Channel

This block takes a 32-bit group of interrupt source lines and gives each of its low ten bits a dedicated output interrupt line. A rising edge on a source line counts as an event when its enable bit is set. Each of the ten low bits keeps its own status bit, its own pending bit and its own output level. Firmware acknowledges one output by writing a one to the matching status bit. That acknowledge either replays a queued event or lowers the line, and it never touches any other bit.

Two registers form the software view. The enable register holds a sticky enable set and drives a mask that firmware toggles while a handler runs. The status register holds set-by-hardware, write-one-to-clear bits. Each of the ten lanes is a small state machine with four states, named by the pair (status, pending):
- QUIET (0,0)
- RAISED (1,0)
- QUEUED (1,1)
- HELD (0,1)

The lane moves as follows:
- A clean event moves QUIET to RAISED.
- A busy event moves RAISED to QUEUED, or QUIET to HELD when the lane is masked.
- An acknowledge moves QUEUED to RAISED (replay), HELD to RAISED (replay), and RAISED to QUIET (drop).
- An all-ones status write moves RAISED to QUIET and QUEUED to HELD without an acknowledge.

Each output line is a separate registered level. It is set on a clean event or a replay, and cleared on a drop.

Top module: `irq_split_chan`

## Requirements
- R1: After reset all ten output lines are low, and both the enable register (wr_sel/rd_sel = 0) and the status register (select = 1) read as zero.
- R2: A rising edge on enabled source bit i (i < 10), when status bit i and mask bit i are both clear, sets status bit i and drives output i high at the next clock edge.
- R3: An edge on a source bit whose enable bit is clear, or on any source bit at position 10 or above, changes no status bit and no output.
- R4: An enabled edge on bit i while status bit i or mask bit i is set leaves status and output i unchanged and records pending bit i. The record is kept until an acknowledge of bit i.
- R5: Enable bits are sticky. A write that adds new enable bits ORs them in, stores the written value as the enable read-back, and leaves the mask unchanged. A zero write while nothing is enabled just stores zero.
- R6: An enable write that adds no new enable bits computes change = read-back XOR data. If change AND data is nonzero, the change bits are unmasked; otherwise the change bits are masked. The read-back becomes data.
- R7: A status write of zero has no effect.
- R8: A status write of all ones clears every status bit and leaves pending bits and output lines unchanged.
- R9: Any other nonzero status write clears the written bits. Then, for each written bit i < 10: if pending bit i is set, status bit i is set again, pending bit i is cleared and output i is driven high; otherwise output i is driven low.
- R10: Acknowledging bit i leaves every other output line and status bit unchanged.
- R11: When a register write and a source edge fall in the same cycle, the write is applied first. The edge is then judged against the resulting enable, mask, status and pending state.
- R12: Status bits 10 to 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source lines, edge detected |
| wr_en | input | 1 | Register write strobe (32-bit write) |
| wr_sel | input | 1 | Write target: 0 enable, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 enable read-back, 1 status |
| rd_data | output | 32 | Read data, combinational from the registers |
| irq_o | output | 10 | Per-bit output interrupt lines |

## Verification
The status acknowledge path and the event path can both act on the same lane in one cycle. For example, an acknowledge of bit i can land in the cycle where source i rises, so a drop and a fresh raise, or a replay and a re-queue, compete for the same state. The bench provokes this directly by acknowledging a raised bit in the edge cycle. It also lets random source toggles overlap random enable and status writes over thousands of cycles. The outputs and read-back are judged against a bench model that applies the write first and the edge second.

// File: rtl/irq_split_pkg.sv
package irq_split_pkg;

    typedef enum logic [1:0] {
        LN_QUIET  = 2'b00,
        LN_HELD   = 2'b01,
        LN_RAISED = 2'b10,
        LN_QUEUED = 2'b11
    } lane_state_e;

    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

endpackage

// File: rtl/irq_split_edge.sv
module irq_split_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level_i;
    end

    assign rise_o = level_i & ~last_q;
endmodule

// File: rtl/irq_split_enmask.sv
module irq_split_enmask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] readback_o,
    output logic [W-1:0] enable_eff_o,
    output logic [W-1:0] mask_eff_o
);
    logic [W-1:0] en_q, mk_q, rb_q;
    logic [W-1:0] en_n, mk_n, rb_n;
    logic [W-1:0] delta;

    always_comb begin
        en_n  = en_q;
        mk_n  = mk_q;
        rb_n  = rb_q;
        delta = rb_q ^ data_i;
        if (wr_i) begin
            if (data_i == '0 && en_q == '0) begin
                rb_n = '0;
            end else if ((en_q | data_i) != en_q) begin
                en_n = en_q | data_i;
                rb_n = data_i;
            end else begin
                if (|(delta & data_i)) mk_n = mk_q & ~delta;
                else                   mk_n = mk_q | delta;
                rb_n = data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            mk_q <= '0;
            rb_q <= '0;
        end else begin
            en_q <= en_n;
            mk_q <= mk_n;
            rb_q <= rb_n;
        end
    end

    assign readback_o   = rb_q;
    assign enable_eff_o = en_n;
    assign mask_eff_o   = mk_n;

    // R5: enable set only grows
    a_r5_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_q)) == $past(en_q)));

    // R5: a write that adds enable bits leaves the mask alone
    a_r5_mask_kept_on_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ((en_q | data_i) != en_q)) |=> $stable(mk_q));
endmodule

// File: rtl/irq_split_lane.sv
module irq_split_lane
    import irq_split_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic masked_i,
    input  logic wipe_i,
    input  logic ack_i,
    output logic status_o,
    output logic irq_o
);
    lane_state_e state_q, state_n;
    logic        out_q, out_n;
    logic        st, pd;

    always_comb begin
        st    = (state_q == LN_RAISED) || (state_q == LN_QUEUED);
        pd    = (state_q == LN_QUEUED) || (state_q == LN_HELD);
        out_n = out_q;
        // register write acts first
        if (wipe_i) st = 1'b0;
        if (ack_i) begin
            if (pd) begin
                st    = 1'b1;
                pd    = 1'b0;
                out_n = 1'b1;
            end else begin
                out_n = 1'b0;
            end
        end
        // then the source event
        if (hit_i) begin
            if (masked_i || st) begin
                pd = 1'b1;
            end else begin
                st    = 1'b1;
                out_n = 1'b1;
            end
        end
        unique case ({st, pd})
            2'b00:   state_n = LN_QUIET;
            2'b01:   state_n = LN_HELD;
            2'b10:   state_n = LN_RAISED;
            default: state_n = LN_QUEUED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_n;
    end

    assign status_o = (state_q == LN_RAISED) || (state_q == LN_QUEUED);
    assign irq_o    = out_q;

    // R2: a line only rises together with its status bit
    a_r2_rise_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> status_o);

    // R4: a recorded event survives until an acknowledge
    a_r4_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LN_QUEUED || state_q == LN_HELD) && !ack_i)
        |=> (state_q == LN_QUEUED || state_q == LN_HELD));

    // R9: acknowledge with nothing recorded and no new event drops the line
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit_i && (state_q == LN_QUIET || state_q == LN_RAISED))
        |=> !out_q);
endmodule

// File: rtl/irq_split_chan.sv
module irq_split_chan
    import irq_split_pkg::*;
#(
    parameter int SRC_W = 32,
    parameter int OUT_N = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [SRC_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [SRC_W-1:0] rd_data,
    output logic [OUT_N-1:0] irq_o
);
    localparam int HI_W = SRC_W - OUT_N;

    logic [SRC_W-1:0] rise, en_eff, mk_eff, en_rb, sel_all, status_w;
    logic [OUT_N-1:0] hits, st_bits;
    logic             st_wr, st_wipe, st_ack;
    logic             hi_unused;

    irq_split_edge #(.W(SRC_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(src_i), .rise_o(rise)
    );

    irq_split_enmask #(.W(SRC_W)) u_enmask (
        .clk(clk), .rst_n(rst_n),
        .wr_i(wr_en && (wr_sel == SEL_ENABLE)),
        .data_i(wr_data),
        .readback_o(en_rb),
        .enable_eff_o(en_eff),
        .mask_eff_o(mk_eff)
    );

    assign sel_all   = rise & en_eff;
    assign hits      = sel_all[OUT_N-1:0];
    assign hi_unused = |{sel_all[SRC_W-1:OUT_N], mk_eff[SRC_W-1:OUT_N]};

    assign st_wr   = wr_en && (wr_sel == SEL_STATUS);
    assign st_wipe = st_wr && (wr_data != '0);
    assign st_ack  = st_wipe && (wr_data != '1);

    for (genvar i = 0; i < OUT_N; i++) begin : g_lane
        irq_split_lane u_lane (
            .clk(clk), .rst_n(rst_n),
            .hit_i(hits[i]),
            .masked_i(mk_eff[i]),
            .wipe_i(st_wipe && wr_data[i]),
            .ack_i(st_ack && wr_data[i]),
            .status_o(st_bits[i]),
            .irq_o(irq_o[i])
        );
    end

    assign status_w = {{HI_W{1'b0}}, st_bits};
    assign rd_data  = (rd_sel == SEL_STATUS) ? status_w : en_rb;

    // R7: zero status write with no event leaves status untouched
    a_r7_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wr_data == '0 && hits == '0) |=> $stable(st_bits));

    // R8: all-ones write with no event leaves the lines untouched
    a_r8_wipe_keeps_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wr_data == '1 && hits == '0) |=> $stable(irq_o));

    // R8: all-ones write with no event empties status
    a_r8_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wr_data == '1 && hits == '0) |=> (st_bits == '0));
endmodule

// File: tb/irq_split_chan_bench.sv
module irq_split_chan_bench;
    localparam int SW = 32;
    localparam int ON = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] src_i, wr_data, rd_data;
    logic          wr_en, wr_sel, rd_sel;
    logic [ON-1:0] irq_o;

    irq_split_chan u_irq_split_chan (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [SW-1:0] m_rb, m_en, m_mk, m_prev;
    logic [ON-1:0] m_st, m_pd, m_out;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rb = '0; m_en = '0; m_mk = '0; m_prev = '0;
        m_st = '0; m_pd = '0; m_out = '0;
    endtask

    task automatic model_step(input logic [31:0] s, input logic we, input logic sel,
                              input logic [31:0] d);
        logic [31:0] rise, chg;
        logic [ON-1:0] hit;
        rise = s & ~m_prev;
        m_prev = s;
        if (we && !sel) begin
            if (d == 0 && m_en == 0) m_rb = 0;
            else if ((m_en | d) != m_en) begin m_en = m_en | d; m_rb = d; end
            else begin
                chg = m_rb ^ d;
                if ((chg & d) != 0) m_mk = m_mk & ~chg;
                else m_mk = m_mk | chg;
                m_rb = d;
            end
        end
        if (we && sel && d != 0) begin
            for (int i = 0; i < ON; i++) begin
                if (d[i]) begin
                    m_st[i] = 1'b0;
                    if (d != 32'hFFFF_FFFF) begin
                        if (m_pd[i]) begin m_st[i] = 1'b1; m_pd[i] = 1'b0; m_out[i] = 1'b1; end
                        else m_out[i] = 1'b0;
                    end
                end
            end
        end
        hit = rise[ON-1:0] & m_en[ON-1:0];
        for (int i = 0; i < ON; i++) begin
            if (hit[i]) begin
                if (m_mk[i] || m_st[i]) m_pd[i] = 1'b1;
                else begin m_st[i] = 1'b1; m_out[i] = 1'b1; end
            end
        end
    endtask

    task automatic cyc(input string tag, input logic [31:0] s, input logic we,
                       input logic sel, input logic [31:0] d, input logic rs);
        @(negedge clk);
        src_i = s; wr_en = we; wr_sel = sel; wr_data = d; rd_sel = rs;
        model_step(s, we, sel, d);
        @(posedge clk);
        #1;
        check(tag, {22'b0, irq_o}, {22'b0, m_out});
        check(tag, rd_data, rs ? {22'b0, m_st} : m_rb);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    logic [31:0] cur;

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; src_i = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq", {22'b0, irq_o}, 32'h0);
        check("R1 enable", rd_data, 32'h0);
        rd_sel = 1'b1; #1;
        check("R1 status", rd_data, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        cur = 0;
        cyc("R1 idle", cur, 0, 0, 0, 1);
        cyc("R5 zero enable", cur, 1, 0, 32'h0, 0);
        cyc("R5 grow", cur, 1, 0, 32'h0000_03FF, 0);
        cur[3] = 1; cyc("R2 raise", cur, 0, 0, 0, 1);
        cur[3] = 0; cyc("R2 low", cur, 0, 0, 0, 1);
        cur[3] = 1; cyc("R4 queue", cur, 0, 0, 0, 1);
        cyc("R9 replay", cur, 1, 1, 32'h8, 1);
        cyc("R9 drop", cur, 1, 1, 32'h8, 1);
        cur[1] = 1; cur[5] = 1; cyc("R2 two", cur, 0, 0, 0, 1);
        cyc("R10 ack one", cur, 1, 1, 32'h2, 1);
        cur[20] = 1; cyc("R3 disabled", cur, 0, 0, 0, 1);
        cyc("R5 grow hi", cur, 1, 0, 32'h0000_13FF, 0);
        cur[12] = 1; cyc("R3 high bit", cur, 0, 0, 0, 1);
        cyc("R12 upper zero", cur, 0, 0, 0, 1);
        cyc("R6 mask", cur, 1, 0, 32'h0000_13F7, 0);
        cur[3] = 0; cyc("R6 low", cur, 0, 0, 0, 1);
        cur[3] = 1; cyc("R4 held", cur, 0, 0, 0, 1);
        cyc("R6 unmask", cur, 1, 0, 32'h0000_13FF, 0);
        cyc("R9 held replay", cur, 1, 1, 32'h8, 1);
        cyc("R8 all ones", cur, 1, 1, 32'hFFFF_FFFF, 1);
        cyc("R7 zero", cur, 1, 1, 32'h0, 1);
        cyc("R9 ack after wipe", cur, 1, 1, 32'h8, 1);
        cur[5] = 0; cyc("R11 prep", cur, 0, 0, 0, 1);
        cur[5] = 1; cyc("R11 ack and edge", cur, 1, 1, 32'h20, 1);
        cur[5] = 0; cyc("R11 prep2", cur, 0, 0, 0, 1);
        cur[5] = 1; cyc("R11 all ones and edge", cur, 1, 1, 32'hFFFF_FFFF, 1);

        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            logic we, sel;
            int k;
            cur = cur ^ ($urandom() & $urandom() & 32'h0000_3FFF);
            k = $urandom_range(0, 9);
            we = (k < 4);
            sel = (k < 3);
            case ($urandom_range(0, 5))
                0: d = 32'h0;
                1: d = 32'hFFFF_FFFF;
                2: d = m_rb ^ (32'h1 << $urandom_range(0, 11));
                3: d = 32'h1 << $urandom_range(0, 11);
                default: d = $urandom() & 32'h0000_0FFF;
            endcase
            cyc("R11 random", cur, we, sel, d, $urandom_range(0, 1) == 1);
        end
        finish_run();
    end
endmodule